// File: doc/BRIEF.md
# Prioritized CAN Acceptance Filter

This block decides which of fifteen receive slots takes a CAN frame once the frame is known to be free of bit errors. Each slot carries an enable, a format bit (standard 11-bit or extended 29-bit identifier), an arbitration identifier, a mask-use bit and a mask select. The block also holds five shared masks. Each masked slot picks one of these masks, so that a group of identifiers can land in the same slot.

All slots are evaluated in parallel in one combinational stage. The slot with the lowest number that passes every enabled test wins. A registered result appears one clock after the frame strobe: a result-valid pulse, a hit flag and the 4-bit number of the winning slot. Configuration is loaded through a simple write port and takes effect for strobes from the following cycle.

Top module: `can_filt_top`

## Requirements
- R1: After reset every slot is disabled, every mask is all ones, and `res_valid`, `hit` and `hit_idx` are 0.
- R2: `res_valid` is 1 in exactly the cycle after each cycle with `frm_valid` high, including back-to-back strobes. When `res_valid` is 0, `hit` and `hit_idx` are 0.
- R3: A strobe with `frm_ok` low (the frame had a bit error) yields `res_valid`=1, `hit`=0 and `hit_idx`=0, whatever the slots hold.
- R4: A slot whose enable bit is 0 never accepts a frame.
- R5: When several enabled slots pass, `hit_idx` gives the lowest-numbered one (1 is the highest priority, 15 the lowest).
- R6: A standard-format slot (format bit 0) compares identifier bits [10:0] only. Bits [28:11] of the frame and of the slot identifier have no effect.
- R7: An extended-format slot (format bit 1) compares all 29 identifier bits [28:0].
- R8: A frame whose format (`frm_ext`) differs from a slot's format bit never matches that slot.
- R9: With mask-use set and a mask select of 0 to 4, the slot compares only the bits where the selected mask holds a 1. Bits where the mask holds a 0 are ignored.
- R10: With mask-use set and a mask select of 5 or above, the slot compares exactly, as if the mask were all ones.
- R11: With mask-use clear, the slot compares exactly, regardless of the contents of the masks.
- R12: Configuration writes to slot number 0 or above 15 change no slot. A valid write affects strobes from the next cycle on.
- R13: If no slot passes a valid, error-free strobe, the result is `res_valid`=1, `hit`=0, `hit_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 4 | Slot number to write, 1 to 15 |
| cfg_en | input | 1 | Slot enable value |
| cfg_ext | input | 1 | Slot format: 0 standard, 1 extended |
| cfg_muse | input | 1 | Slot mask-use bit |
| cfg_msel | input | 3 | Mask select for the slot |
| cfg_id | input | 29 | Slot arbitration identifier |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 3 | Mask number to write, 0 to 4 |
| mask_val | input | 29 | Mask value, 1 = bit must match |
| frm_valid | input | 1 | Received-frame strobe, one cycle |
| frm_ok | input | 1 | Frame free of bit errors |
| frm_ext | input | 1 | Frame format: 0 standard, 1 extended |
| frm_id | input | 29 | Frame identifier (standard in [10:0]) |
| res_valid | output | 1 | Result pulse, one cycle after `frm_valid` |
| hit | output | 1 | A slot accepted the frame |
| hit_idx | output | 4 | Winning slot number, 0 when no hit |

## Verification
A corrupted slot register or mask register shows at the ports on the next strobe whose identifier touches it. It appears as a missing hit, a wrong slot number or a hit where none was due, one cycle after that strobe. A fault in the priority order only appears when two enabled slots pass at once, so the tests load overlapping slots on purpose. A fault in the result pipeline shows within one cycle as a result pulse that is missing, doubled or misplaced relative to `frm_valid`.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  // Identifier widths fixed by the bus protocol
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef logic [ID_W-1:0] can_id_t;

  typedef struct packed {
    logic    en;
    logic    ext;
    logic    muse;
    can_id_t id;
  } slot_cfg_t;

  localparam can_id_t STD_FIELD = can_id_t'({STD_W{1'b1}});
  localparam can_id_t ALL_ONES  = '1;
endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int NUM_MASKS = 5,
  parameter int IDX_W = 4,
  parameter int SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_slot,
  input  slot_cfg_t            cfg_data,
  input  logic [SEL_W-1:0]     cfg_msel,
  input  logic                 mask_we,
  input  logic [SEL_W-1:0]     mask_sel,
  input  can_id_t              mask_val,
  output slot_cfg_t            slots [NUM_SLOTS],
  output logic [SEL_W-1:0]     msels [NUM_SLOTS],
  output can_id_t              masks [NUM_MASKS]
);
  // One register set per slot; slot k lives at array index k-1
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_NUM = IDX_W'(s + 1);
    logic wr_hit;
    assign wr_hit = cfg_we && (cfg_slot == SLOT_NUM);

    always_ff @(posedge clk) begin
      if (rst) begin
        slots[s] <= '0;
        msels[s] <= '0;
      end else if (wr_hit) begin
        slots[s] <= cfg_data;
        msels[s] <= cfg_msel;
      end
    end
  end

  for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
    localparam logic [SEL_W-1:0] MASK_NUM = SEL_W'(m);
    always_ff @(posedge clk) begin
      if (rst)
        masks[m] <= ALL_ONES;
      else if (mask_we && (mask_sel == MASK_NUM))
        masks[m] <= mask_val;
    end
  end
endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp
  import can_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int NUM_MASKS = 5,
  parameter int SEL_W = 3
) (
  input  slot_cfg_t            slots [NUM_SLOTS],
  input  logic [SEL_W-1:0]     msels [NUM_SLOTS],
  input  can_id_t              masks [NUM_MASKS],
  input  logic                 frm_ext,
  input  can_id_t              frm_id,
  output logic [NUM_SLOTS-1:0] pass
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    can_id_t sel_mask;
    can_id_t eff_mask;
    can_id_t diff;

    // Mask choice: exact unless mask-use is set and the select names a real mask
    always_comb begin
      sel_mask = ALL_ONES;
      if (slots[s].muse) begin
        for (int m = 0; m < NUM_MASKS; m++) begin
          if (msels[s] == SEL_W'(m)) sel_mask = masks[m];
        end
      end
    end

    // Standard slots look at the low identifier field only
    assign eff_mask = slots[s].ext ? sel_mask : (sel_mask & STD_FIELD);
    assign diff     = (frm_id ^ slots[s].id) & eff_mask;

    assign pass[s] = slots[s].en
                  && (slots[s].ext == frm_ext)
                  && (diff == '0);
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int NUM_SLOTS = 15,
  parameter int IDX_W = 4
) (
  input  logic [NUM_SLOTS-1:0] pass,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  // Scan from the top down so the lowest passing slot is the last to write
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (pass[s]) begin
        found = 1'b1;
        idx   = IDX_W'(s + 1);
      end
    end
  end
endmodule

// File: rtl/can_filt_top.sv
module can_filt_top
  import can_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int NUM_MASKS = 5,
  localparam int IDX_W = $clog2(NUM_SLOTS + 1),
  localparam int SEL_W = $clog2(NUM_MASKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_slot,
  input  logic             cfg_en,
  input  logic             cfg_ext,
  input  logic             cfg_muse,
  input  logic [SEL_W-1:0] cfg_msel,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic             mask_we,
  input  logic [SEL_W-1:0] mask_sel,
  input  logic [ID_W-1:0]  mask_val,
  input  logic             frm_valid,
  input  logic             frm_ok,
  input  logic             frm_ext,
  input  logic [ID_W-1:0]  frm_id,
  output logic             res_valid,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  slot_cfg_t            cfg_data;
  slot_cfg_t            slots [NUM_SLOTS];
  logic [SEL_W-1:0]     msels [NUM_SLOTS];
  can_id_t              masks [NUM_MASKS];
  logic [NUM_SLOTS-1:0] pass;
  logic [NUM_SLOTS-1:0] slot_en;
  logic                 found;
  logic [IDX_W-1:0]     win_idx;

  assign cfg_data = '{en: cfg_en, ext: cfg_ext, muse: cfg_muse, id: cfg_id};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_en
    assign slot_en[s] = slots[s].en;
  end

  can_filt_cfg #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_MASKS(NUM_MASKS), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_slot),
    .cfg_data (cfg_data),
    .cfg_msel (cfg_msel),
    .mask_we  (mask_we),
    .mask_sel (mask_sel),
    .mask_val (mask_val),
    .slots    (slots),
    .msels    (msels),
    .masks    (masks)
  );

  can_filt_cmp #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_MASKS(NUM_MASKS), .SEL_W(SEL_W)
  ) u_cmp (
    .slots   (slots),
    .msels   (msels),
    .masks   (masks),
    .frm_ext (frm_ext),
    .frm_id  (frm_id),
    .pass    (pass)
  );

  can_filt_prio #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
  ) u_prio (
    .pass  (pass),
    .found (found),
    .idx   (win_idx)
  );

  // Result register: one cycle after the strobe; a frame with errors never hits
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      res_valid <= frm_valid;
      hit       <= frm_valid && frm_ok && found;
      hit_idx   <= (frm_valid && frm_ok && found) ? win_idx : '0;
    end
  end
endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
  parameter int NUM_SLOTS = 15,
  parameter int IDX_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frm_valid,
  input logic                 frm_ok,
  input logic                 res_valid,
  input logic                 hit,
  input logic [IDX_W-1:0]     hit_idx,
  input logic [NUM_SLOTS-1:0] slot_en
);
  // Enables as seen at the strobe cycle
  logic [NUM_SLOTS-1:0] en_d;
  always_ff @(posedge clk) begin
    if (rst) en_d <= '0;
    else     en_d <= slot_en;
  end

  assert_res_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> res_valid);
  assert_no_res_without_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !res_valid);
  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!hit && hit_idx == '0));
  assert_bad_frame_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_ok) |=> (!hit && hit_idx == '0));
  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_idx >= IDX_W'(1) && hit_idx <= IDX_W'(NUM_SLOTS)));
  assert_winner_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    hit |-> en_d[hit_idx - IDX_W'(1)]);
  assert_miss_zero_idx_R13: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !hit) |-> hit_idx == '0);
endmodule

bind can_filt_top can_filt_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frm_valid (frm_valid),
  .frm_ok    (frm_ok),
  .res_valid (res_valid),
  .hit       (hit),
  .hit_idx   (hit_idx),
  .slot_en   (slot_en)
);

// File: tb/can_filt_top_tb.sv
`timescale 1ns/1ps
module can_filt_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic        cfg_en = 1'b0, cfg_ext = 1'b0, cfg_muse = 1'b0;
  logic [2:0]  cfg_msel = '0;
  logic [28:0] cfg_id = '0;
  logic        mask_we = 1'b0;
  logic [2:0]  mask_sel = '0;
  logic [28:0] mask_val = '0;
  logic        frm_valid = 1'b0, frm_ok = 1'b0, frm_ext = 1'b0;
  logic [28:0] frm_id = '0;
  logic        res_valid, hit;
  logic [3:0]  hit_idx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_filt_top u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_en(cfg_en), .cfg_ext(cfg_ext),
    .cfg_muse(cfg_muse), .cfg_msel(cfg_msel), .cfg_id(cfg_id),
    .mask_we(mask_we), .mask_sel(mask_sel), .mask_val(mask_val),
    .frm_valid(frm_valid), .frm_ok(frm_ok), .frm_ext(frm_ext), .frm_id(frm_id),
    .res_valid(res_valid), .hit(hit), .hit_idx(hit_idx)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr_slot(input int slot, input bit en, input bit ext,
                         input bit muse, input int msel, input logic [28:0] id);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 4'(slot); cfg_en = en; cfg_ext = ext;
    cfg_muse = muse; cfg_msel = 3'(msel); cfg_id = id;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_mask(input int sel, input logic [28:0] val);
    @(negedge clk);
    mask_we = 1'b1; mask_sel = 3'(sel); mask_val = val;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  // One strobe, then check the registered result one cycle later
  task automatic probe(input string tag, input bit ok, input bit ext,
                       input logic [28:0] id, input int exp_idx);
    @(negedge clk);
    frm_valid = 1'b1; frm_ok = ok; frm_ext = ext; frm_id = id;
    @(negedge clk);
    frm_valid = 1'b0;
    chk({tag, " res_valid"}, int'(res_valid), 1);
    chk({tag, " hit"}, int'(hit), exp_idx != 0 ? 1 : 0);
    chk({tag, " idx"}, int'(hit_idx), exp_idx);
  endtask

  task automatic t_reset();
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 hit", int'(hit), 0);
    chk("R1 idx", int'(hit_idx), 0);
    probe("R1 empty", 1, 0, 29'h000, 0);
    probe("R13 miss ext", 1, 1, 29'h0, 0);
  endtask

  task automatic t_standard();
    wr_slot(3, 1, 0, 0, 0, 29'h123);
    probe("R6 exact", 1, 0, 29'h123, 3);
    probe("R6 upper ignored", 1, 0, 29'h1FFFF123, 3);
    probe("R6 low bit differs", 1, 0, 29'h124, 0);
    wr_slot(4, 1, 0, 0, 0, 29'h1AAAA456);
    probe("R6 slot upper ignored", 1, 0, 29'h456, 4);
  endtask

  task automatic t_extended();
    wr_slot(5, 1, 1, 0, 0, 29'h0ABCDEF1);
    probe("R7 exact", 1, 1, 29'h0ABCDEF1, 5);
    probe("R7 bit28", 1, 1, 29'h1ABCDEF1, 0);
    probe("R8 std frame vs ext slot", 1, 0, 29'h0ABCDEF1, 0);
    probe("R8 ext frame vs std slot", 1, 1, 29'h123, 0);
  endtask

  task automatic t_priority();
    wr_slot(9, 1, 0, 0, 0, 29'h055);
    wr_slot(7, 1, 0, 0, 0, 29'h055);
    probe("R5 lower wins", 1, 0, 29'h055, 7);
    wr_slot(7, 0, 0, 0, 0, 29'h055);
    probe("R4 disabled skipped", 1, 0, 29'h055, 9);
    wr_slot(1, 1, 0, 0, 0, 29'h055);
    probe("R5 slot1 top", 1, 0, 29'h055, 1);
  endtask

  task automatic t_masks();
    wr_mask(2, 29'h7F0);
    wr_slot(10, 1, 0, 1, 2, 29'h230);
    probe("R9 masked hit", 1, 0, 29'h23A, 10);
    probe("R9 cared bit differs", 1, 0, 29'h33A, 0);
    wr_slot(10, 1, 0, 0, 2, 29'h230);
    probe("R11 no mask use", 1, 0, 29'h23A, 0);
    wr_slot(10, 1, 0, 1, 6, 29'h230);
    probe("R10 sel6 exact miss", 1, 0, 29'h23A, 0);
    probe("R10 sel6 exact hit", 1, 0, 29'h230, 10);
    wr_mask(4, 29'h1FFFFF00);
    wr_slot(11, 1, 1, 1, 4, 29'h12345600);
    probe("R9 ext mask4", 1, 1, 29'h123456FF, 11);
  endtask

  task automatic t_bad_frame();
    probe("R3 error frame", 0, 0, 29'h123, 0);
  endtask

  task automatic t_slot_bounds();
    wr_slot(0, 1, 0, 0, 0, 29'h7FF);
    probe("R12 slot0 ignored", 1, 0, 29'h7FF, 0);
    wr_slot(15, 1, 0, 0, 0, 29'h7FF);
    probe("R12 slot15", 1, 0, 29'h7FF, 15);
  endtask

  task automatic t_timing();
    // Write then strobe in the very next cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 4'd12; cfg_en = 1'b1; cfg_ext = 1'b0;
    cfg_muse = 1'b0; cfg_msel = 3'd0; cfg_id = 29'h3C3;
    @(negedge clk);
    cfg_we = 1'b0;
    frm_valid = 1'b1; frm_ok = 1'b1; frm_ext = 1'b0; frm_id = 29'h3C3;
    @(negedge clk);
    chk("R12 next-cycle write idx", int'(hit_idx), 12);
    frm_id = 29'h123;
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R2 back-to-back valid", int'(res_valid), 1);
    chk("R2 back-to-back idx", int'(hit_idx), 3);
    @(negedge clk);
    chk("R2 no strobe res_valid", int'(res_valid), 0);
    chk("R2 no strobe hit", int'(hit), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_standard();
    t_extended();
    t_priority();
    t_masks();
    t_bad_frame();
    t_slot_bounds();
    t_timing();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule